// File: doc/BRIEF.md
# Local Bus Ownership Requester with Direct-Slave Preemption

This block decides who in a bridge may own a shared local bus. It serves two internal clients: a DMA engine and a direct-slave path carrying accesses that arrive from the upstream side. It talks to an external arbiter through one hold-request output and one hold-acknowledge input. A second output marks a request as being made for the direct-slave path. The block also drives the enable for the bridge's local output drivers.

The direct-slave client always wins. If a slave access arrives while DMA owns the bus, the requester lets the DMA burst finish at most a fixed number of longword beats. It then drops its request and tristates the outputs. It waits for the arbiter to withdraw acknowledge, and then requests the bus again, this time flagged as a slave request. When the slave access completes, the bus is released in the same way. DMA may re-request only after acknowledge is seen low and a pause timer has run out. The timer is reloaded from a configuration input each time DMA gives the bus up, and it counts down one step per clock.

Top module: `lbus_owner_arb`

## Requirements
- R1: While reset is active, and afterwards with no request pending, hold_req, slv_hold, bus_oe, dma_grant and slv_grant are all 0 (idle, outputs tristated).
- R2: From idle, when dma_req is 1, hold_ack is 0 and the pause timer is zero, hold_req rises one clock later with slv_hold 0. A sampled hold_ack then raises dma_grant and bus_oe one clock later.
- R3: While DMA owns the bus, dma_req going to 0 drops hold_req, bus_oe and dma_grant one clock later. The pause timer is loaded with pause_cfg on that edge.
- R4: While DMA owns the bus and slv_req is 1, each cycle with dma_beat 1 counts one longword beat. Beats seen while slv_req is 0 are not counted. Ownership continues until the edge on which the BEAT_LIMIT-th counted beat completes (default 2). On that edge hold_req and bus_oe drop.
- R5: If dma_req falls during a preemption before the beat limit is reached, the bus is released on the next edge.
- R6: After a release for preemption, hold_req and slv_hold are both raised only on the edge after hold_ack is sampled 0. While hold_ack stays 1, both stay 0.
- R7: With a slave request outstanding, a sampled hold_ack raises slv_grant and bus_oe one clock later, while hold_req and slv_hold stay 1.
- R8: A slv_done pulse during slave ownership drops hold_req, slv_hold, bus_oe and slv_grant one clock later.
- R9: DMA re-requests (hold_req 1, slv_hold 0) only when, in idle, hold_ack is 0 and the pause timer is zero. The timer counts down one per clock from pause_cfg, so after a DMA release with acknowledge already low, hold_req returns pause_cfg+1 clocks after the release edge. It stays 0 while hold_ack is 1.
- R10: Slave requests take priority. With both requests pending in idle, the slave request is made. A slave request arriving while the DMA request is still unacknowledged withdraws it and loads the pause timer.
- R11: If hold_ack is withdrawn while DMA owns the bus, hold_req, bus_oe and dma_grant drop one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_req | input | 1 | DMA engine wants the bus (level) |
| dma_beat | input | 1 | One longword DMA beat completed this cycle |
| slv_req | input | 1 | Direct-slave access pending (level) |
| slv_done | input | 1 | Direct-slave transfer finished (pulse) |
| hold_ack | input | 1 | Bus grant from the external arbiter |
| pause_cfg | input | PAUSE_W | Pause timer reload value |
| hold_req | output | 1 | Bus request to the arbiter |
| slv_hold | output | 1 | Marks the current request as direct-slave |
| bus_oe | output | 1 | Enable for the local output drivers |
| dma_grant | output | 1 | DMA may transfer |
| slv_grant | output | 1 | Direct-slave transfer may proceed |

## Verification
The bench builds the block with BEAT_LIMIT at 2 and PAUSE_W at 8, and drives pause_cfg at 3. This keeps the exact edge of the forced release, and the pause window after each DMA release, within a few cycles that can be counted by hand. It is enough to see the timer hold off a DMA re-request, expire during a slave access, and be overridden by a lingering acknowledge. Preemption is exercised both at the beat limit and by an early end of the DMA burst. Acknowledge is also withdrawn by the arbiter in the middle of a DMA burst.

// File: rtl/lbus_owner_pkg.sv
// Shared types for the local bus ownership requester.
// Assumes nothing beyond IEEE 1800-2017 packages.
package lbus_owner_pkg;

    // Ownership sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_DMA_WAIT  = 3'd1,
        ST_DMA_OWN   = 3'd2,
        ST_DMA_YIELD = 3'd3,
        ST_SLV_WAIT  = 3'd4,
        ST_SLV_OWN   = 3'd5,
        ST_SLV_REL   = 3'd6
    } own_state_t;

endpackage

// File: rtl/lbus_preempt_beats.sv
// Counts completed DMA longword beats once a direct-slave request is
// pending during DMA ownership, and flags the beat that reaches the limit.
// Assumes count_en is low whenever DMA does not own the bus; the count
// clears whenever count_en is low.
module lbus_preempt_beats #(
    parameter int BEAT_LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic beat,
    output logic limit_hit
);
    localparam int CW = $clog2(BEAT_LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(BEAT_LIMIT - 1);

    logic [CW-1:0] cnt;

    // Beat that completes the allowed count during preemption.
    assign limit_hit = count_en && beat && (cnt == LAST);

    // Count beats while preempting; clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !count_en) begin
            cnt <= '0;
        end else if (beat && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the counter never passes the last allowed beat index.
    assert_beat_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/lbus_pause_timer.sv
// Down-counter that holds off DMA re-requests. Loaded from a
// configuration value on load, then counts down once per clock to zero.
// Assumes load is a single-cycle pulse.
module lbus_pause_timer #(
    parameter int PAUSE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PAUSE_W-1:0] cfg,
    output logic               is_zero
);
    logic [PAUSE_W-1:0] cnt;

    assign is_zero = (cnt == '0);

    // Reload on DMA release, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= cfg;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R3: a load places the configured value in the timer.
    assert_pause_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(cfg)));

    // R9: a nonzero timer falls by exactly one per clock when not reloaded.
    assert_pause_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/lbus_owner_fsm.sv
// Ownership sequencer. Requests the local bus for DMA or the
// direct-slave path, gives slave requests priority, and always releases
// the bus fully (request low, acknowledge seen low) before asking again.
// Outputs are decoded from the state register only.
// Assumes preempt_hit comes from the beat counter and pause_zero from
// the pause timer.
module lbus_owner_fsm
    import lbus_owner_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dma_req,
    input  logic slv_req,
    input  logic slv_done,
    input  logic hold_ack,
    input  logic preempt_hit,
    input  logic pause_zero,
    output logic hold_req,
    output logic slv_hold,
    output logic bus_oe,
    output logic dma_grant,
    output logic slv_grant,
    output logic pause_load
);
    own_state_t state, nxt;

    // Next-state selection with slave priority.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (slv_req && !hold_ack)
                    nxt = ST_SLV_WAIT;
                else if (dma_req && !hold_ack && pause_zero)
                    nxt = ST_DMA_WAIT;
            end
            ST_DMA_WAIT: begin
                if (slv_req || !dma_req)
                    nxt = ST_DMA_YIELD;
                else if (hold_ack)
                    nxt = ST_DMA_OWN;
            end
            ST_DMA_OWN: begin
                if (!dma_req || !hold_ack || preempt_hit)
                    nxt = ST_DMA_YIELD;
            end
            ST_DMA_YIELD: begin
                if (!hold_ack)
                    nxt = slv_req ? ST_SLV_WAIT : ST_IDLE;
            end
            ST_SLV_WAIT: begin
                if (hold_ack)
                    nxt = ST_SLV_OWN;
            end
            ST_SLV_OWN: begin
                if (slv_done)
                    nxt = ST_SLV_REL;
            end
            ST_SLV_REL: begin
                if (!hold_ack)
                    nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Output decode from state.
    always_comb begin
        hold_req  = (state == ST_DMA_WAIT) || (state == ST_DMA_OWN) ||
                    (state == ST_SLV_WAIT) || (state == ST_SLV_OWN);
        slv_hold  = (state == ST_SLV_WAIT) || (state == ST_SLV_OWN);
        bus_oe    = (state == ST_DMA_OWN)  || (state == ST_SLV_OWN);
        dma_grant = (state == ST_DMA_OWN);
        slv_grant = (state == ST_SLV_OWN);
    end

    // Pause reload whenever DMA gives up the bus or its request.
    assign pause_load = (nxt == ST_DMA_YIELD) && (state != ST_DMA_YIELD);

    // R6: any new request is made only after acknowledge was seen low.
    assert_rerequest_after_ack_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_req) |-> $past(!hold_ack));

    // R9: a DMA request starts only with the pause timer at zero.
    assert_dma_waits_pause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hold_req) && !slv_hold) |-> $past(pause_zero));

    // R2: drivers are enabled only after an acknowledge was sampled.
    assert_oe_after_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> $past(hold_ack));

    // R10: the slave path and DMA are never granted together.
    assert_single_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_grant && slv_grant));

    // R7: the slave marker never appears without a bus request.
    assert_slv_hold_with_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slv_hold |-> hold_req);

    // R8: slave completion drops the request and the drivers.
    assert_slv_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_grant && slv_done) |=> (!hold_req && !slv_hold && !bus_oe));

endmodule

// File: rtl/lbus_owner_arb.sv
// Local bus ownership requester: top level. Ties the ownership
// sequencer to the preemption beat counter and the DMA pause timer.
// Assumes dma_beat is only meaningful while dma_grant is high and that
// slv_req stays high until slv_done.
module lbus_owner_arb #(
    parameter int BEAT_LIMIT = 2,
    parameter int PAUSE_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dma_req,
    input  logic               dma_beat,
    input  logic               slv_req,
    input  logic               slv_done,
    input  logic               hold_ack,
    input  logic [PAUSE_W-1:0] pause_cfg,
    output logic               hold_req,
    output logic               slv_hold,
    output logic               bus_oe,
    output logic               dma_grant,
    output logic               slv_grant
);
    logic preempt_hit;
    logic pause_zero;
    logic pause_load;
    logic preempting;

    // Beats are counted only while a slave request waits on DMA.
    assign preempting = dma_grant && slv_req;

    lbus_preempt_beats #(.BEAT_LIMIT(BEAT_LIMIT)) u_beats (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (preempting),
        .beat      (dma_beat),
        .limit_hit (preempt_hit)
    );

    lbus_pause_timer #(.PAUSE_W(PAUSE_W)) u_pause (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pause_load),
        .cfg     (pause_cfg),
        .is_zero (pause_zero)
    );

    lbus_owner_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .dma_req     (dma_req),
        .slv_req     (slv_req),
        .slv_done    (slv_done),
        .hold_ack    (hold_ack),
        .preempt_hit (preempt_hit),
        .pause_zero  (pause_zero),
        .hold_req    (hold_req),
        .slv_hold    (slv_hold),
        .bus_oe      (bus_oe),
        .dma_grant   (dma_grant),
        .slv_grant   (slv_grant),
        .pause_load  (pause_load)
    );

    // R4: the limiting beat ends DMA ownership on the next edge.
    assert_preempt_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_hit |=> (!dma_grant && !hold_req && !bus_oe));

    // R3: DMA giving up its request releases the bus.
    assert_dma_end_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_grant && !dma_req) |=> !dma_grant);

endmodule

// File: tb/sim_lbus_owner_arb.sv
// Scoreboard bench: the driver task applies one cycle of stimulus and
// queues the output word expected after the next edge; the monitor pops
// and compares just after each rising edge.
module sim_lbus_owner_arb;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dma_req = 1'b0, dma_beat = 1'b0, slv_req = 1'b0;
    logic          slv_done = 1'b0, hold_ack = 1'b0;
    logic [PW-1:0] pause_cfg = 8'd3;
    logic          hold_req, slv_hold, bus_oe, dma_grant, slv_grant;

    int unsigned n_chk = 0, n_bad = 0, n_cyc = 0;
    logic [4:0]  exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;  // 125 MHz

    lbus_owner_arb #(.BEAT_LIMIT(2), .PAUSE_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_beat(dma_beat),
        .slv_req(slv_req), .slv_done(slv_done), .hold_ack(hold_ack),
        .pause_cfg(pause_cfg), .hold_req(hold_req), .slv_hold(slv_hold),
        .bus_oe(bus_oe), .dma_grant(dma_grant), .slv_grant(slv_grant)
    );

    // Output word order: {hold_req, slv_hold, bus_oe, dma_grant, slv_grant}
    localparam logic [4:0] IDLE = 5'b00000, DWAIT = 5'b10000, DOWN = 5'b10110;
    localparam logic [4:0] SWAIT = 5'b11000, SOWN = 5'b11101;

    // Driver: one cycle of stimulus plus the expected outputs after the edge.
    task automatic cyc(input logic dr, input logic bt, input logic sr,
                       input logic sd, input logic ak, input logic [4:0] e,
                       input string t);
        @(negedge clk);
        dma_req = dr; dma_beat = bt; slv_req = sr; slv_done = sd; hold_ack = ak;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    // Monitor: compare after each edge against the queued expectation.
    always begin
        @(posedge clk);
        #2;
        if (exp_q.size() > 0) begin
            logic [4:0] e;
            logic [4:0] a;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {hold_req, slv_hold, bus_oe, dma_grant, slv_grant};
            n_chk++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s: got %b expected %b at %0t", t, a, e, $time);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 5000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected under 5000", n_cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cyc(1, 0, 1, 0, 0, IDLE, "R1 in reset");
        cyc(1, 0, 1, 0, 0, IDLE, "R1 in reset");
        @(negedge clk); rst_n = 1'b1;
        exp_q.push_back(IDLE); tag_q.push_back("R1 idle after reset");
        dma_req = 0; slv_req = 0;
        cyc(0, 0, 0, 0, 0, IDLE, "R1 idle no request");

        // R2: DMA request and grant; beats without slave request not counted (R4)
        cyc(1, 0, 0, 0, 0, DWAIT, "R2 dma request");
        cyc(1, 0, 0, 0, 1, DOWN,  "R2 dma owns");
        cyc(1, 1, 0, 0, 1, DOWN,  "R4 beat without slave");
        cyc(1, 1, 0, 0, 1, DOWN,  "R4 beat without slave");
        // R3: DMA ends, pause = 3
        cyc(0, 0, 0, 0, 1, IDLE,  "R3 dma release");
        // R9: pause hold-off, then acknowledge-high hold-off
        cyc(1, 0, 0, 0, 0, IDLE,  "R9 pause 2");
        cyc(1, 0, 0, 0, 0, IDLE,  "R9 pause 1");
        cyc(1, 0, 0, 0, 1, IDLE,  "R9 pause 0 ack high");
        cyc(1, 0, 0, 0, 0, DWAIT, "R9 dma re-request");
        cyc(1, 0, 0, 0, 1, DOWN,  "R2 dma owns again");

        // R4: preemption after two counted beats
        cyc(1, 0, 1, 0, 1, DOWN,  "R4 slave pending no beat");
        cyc(1, 1, 1, 0, 1, DOWN,  "R4 first beat");
        cyc(1, 0, 1, 0, 1, DOWN,  "R4 gap");
        cyc(1, 1, 1, 0, 1, IDLE,  "R4 second beat releases");
        // R6: wait for acknowledge low
        cyc(1, 0, 1, 0, 1, IDLE,  "R6 ack still high");
        cyc(1, 0, 1, 0, 0, SWAIT, "R6 slave request");
        cyc(1, 0, 1, 0, 0, SWAIT, "R6 slave waiting");
        // R7, R8
        cyc(1, 0, 1, 0, 1, SOWN,  "R7 slave owns");
        cyc(1, 0, 1, 0, 1, SOWN,  "R7 slave holds");
        cyc(1, 0, 1, 1, 1, IDLE,  "R8 slave done");
        cyc(1, 0, 0, 0, 1, IDLE,  "R8 ack lingering");
        cyc(1, 0, 0, 0, 0, IDLE,  "R8 back to idle");
        cyc(1, 0, 0, 0, 0, DWAIT, "R9 dma resumes timer expired");
        cyc(1, 0, 0, 0, 1, DOWN,  "R2 dma owns");

        // R5: DMA ends before the beat limit
        cyc(1, 0, 1, 0, 1, DOWN,  "R5 slave pending");
        cyc(0, 0, 1, 0, 1, IDLE,  "R5 early release");
        cyc(0, 0, 1, 0, 0, SWAIT, "R5 slave request");
        cyc(0, 0, 1, 0, 1, SOWN,  "R7 slave owns");
        cyc(0, 0, 1, 1, 1, IDLE,  "R8 slave done");
        cyc(0, 0, 0, 0, 0, IDLE,  "R1 idle");

        // R10: both pending in idle, slave wins
        cyc(1, 0, 1, 0, 0, SWAIT, "R10 slave first");
        cyc(1, 0, 1, 0, 1, SOWN,  "R10 slave owns");
        cyc(1, 0, 1, 1, 1, IDLE,  "R8 slave done");
        cyc(1, 0, 0, 0, 0, IDLE,  "R8 idle");
        cyc(1, 0, 0, 0, 0, DWAIT, "R2 dma request");
        // R10: slave arrives before DMA acknowledge
        cyc(1, 0, 1, 0, 0, IDLE,  "R10 dma request withdrawn");
        cyc(1, 0, 1, 0, 0, SWAIT, "R10 slave request");
        cyc(1, 0, 1, 0, 1, SOWN,  "R10 slave owns");
        cyc(1, 0, 1, 1, 1, IDLE,  "R8 slave done");
        cyc(1, 0, 0, 0, 0, IDLE,  "R8 idle");
        cyc(1, 0, 0, 0, 0, DWAIT, "R9 dma after pause");

        // R11: acknowledge withdrawn during DMA
        cyc(1, 0, 0, 0, 1, DOWN,  "R2 dma owns");
        cyc(1, 0, 0, 0, 0, IDLE,  "R11 ack revoked");
        cyc(1, 0, 0, 0, 0, IDLE,  "R9 pause 2");
        cyc(1, 0, 0, 0, 0, IDLE,  "R9 pause 1");
        cyc(1, 0, 0, 0, 0, IDLE,  "R9 pause 0");
        cyc(1, 0, 0, 0, 0, DWAIT, "R9 dma re-request");

        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule